// File: doc/BRIEF.md
# Add-Family Carry and Overflow Unit

This unit is the arithmetic core for the integer add and subtract family of a 64-bit processor. One opcode selects how three things reach a single 64-bit adder: operand A, plain or inverted; the second operand, which is source B, the sign-extended 16-bit immediate, zero or all-ones; and the carry-in, which is 0, 1, the stored carry flag or the stored overflow flag. The sum and four result flags are produced combinationally. The flags are carry and overflow, each at full 64-bit width and at 32-bit width.

A small registered flag file holds five bits: carry (CA), 32-bit carry (CA32), overflow (OV), 32-bit overflow (OV32) and a sticky summary overflow (SO). Two enables from the decoder control updates. One enables the carry output and the other enables overflow recording. Updates take effect on the clock edge after a valid operation. The stored flags are read back as carry-in before they are updated. The overflow-carry add variant is different: it takes OV as its carry-in and returns its carries into OV and OV32 rather than CA and CA32. An opcode outside the supported set is reported as illegal and changes nothing.

Top module: `addcy_unit`

## Requirements
- R1: The immediate is sign-extended from bit 15 to 64 bits before it is used by the immediate forms.
- R2: Opcodes that take a fixed carry-in: 0 adds A+B+0, 1 adds A+imm+0, 2 adds ~A+B+1, 3 adds ~A+imm+1, 4 negates as ~A+0+1.
- R3: Extended opcodes take the stored CA as carry-in: 5 adds A+B, 6 adds ~A+B, 7 adds A+all-ones, 8 adds A+0, 9 adds ~A+all-ones, 10 adds ~A+0.
- R4: `res_ca` is the carry out of bit 63. `res_ca32` is the carry out of bit 31 of the low-half addition.
- R5: `res_ov` is the carry out of bit 63 XOR the carry out of bit 62. `res_ov32` is the carry out of bit 31 XOR the carry out of bit 30.
- R6: Opcode 11 adds A+B with stored OV as carry-in. It reports its 64-bit and 32-bit carries on `res_ov`/`res_ov32` and also on `res_ca`/`res_ca32`. When `ca_wen` is set it writes those carries into OV and OV32, and it never changes CA or CA32.
- R7: When `ov_wen` is set on a valid legal operation, OV and OV32 take `res_ov`/`res_ov32` and SO becomes SO OR `res_ov`. SO never clears except by reset.
- R8: For opcodes 0 to 10, CA and CA32 take `res_ca`/`res_ca32` only when `ca_wen` is set on a valid operation. Otherwise they hold.
- R9: Opcodes 12 to 15 with `valid` high drive `illegal` high in that cycle and leave all five flags unchanged. `illegal` is low whenever `valid` is low.
- R10: A synchronous active-low reset clears all five flags. Flag updates appear after the clock edge that samples a valid operation. A cycle with `valid` low changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid | input | 1 | Operation present this cycle |
| opcode | input | 4 | Operation select, encodings in R2, R3, R6 and R9 |
| src_a | input | 64 | Source operand A |
| src_b | input | 64 | Source operand B |
| imm | input | 16 | Signed immediate |
| ca_wen | input | 1 | Carry output enable |
| ov_wen | input | 1 | Overflow recording enable |
| sum | output | 64 | Adder result |
| res_ca | output | 1 | 64-bit carry of this operation |
| res_ca32 | output | 1 | 32-bit carry of this operation |
| res_ov | output | 1 | 64-bit overflow of this operation |
| res_ov32 | output | 1 | 32-bit overflow of this operation |
| illegal | output | 1 | Unsupported opcode with valid |
| flag_ca | output | 1 | Stored CA |
| flag_ca32 | output | 1 | Stored CA32 |
| flag_ov | output | 1 | Stored OV |
| flag_ov32 | output | 1 | Stored OV32 |
| flag_so | output | 1 | Stored sticky summary overflow |

## Verification
The operand pair 0x7FFF_FFFF_FFFF_FFFF + 1 overflows at 64 bits, carries at 32 bits and does not overflow at 32 bits. A design that mixes up the carry points or the widths reports the wrong OV32 or CA32 for it. The pair 0xFFFF_FFFF + 1 carries out of the low half only, which exposes a 32-bit carry taken from the wrong bit. Immediates with bit 15 set show whether sign extension is missing, and every extended form is run with the stored carry both clear and set. This catches a carry-in that is ignored or taken from the wrong flag. The overflow-carry variant, a sticky SO followed by a non-overflowing write, cleared enables and illegal opcodes together reveal flags that are written when they should hold.

// File: rtl/addcy_pkg.sv
// Shared types for the add-family carry and overflow unit.
// Assumes the opcode field is four bits wide. Codes 12 to 15 are unsupported.
package addcy_pkg;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_ADDI   = 4'd1,
        OP_SUB    = 4'd2,
        OP_SUBI   = 4'd3,
        OP_NEG    = 4'd4,
        OP_ADDX   = 4'd5,
        OP_SUBX   = 4'd6,
        OP_ADDMX  = 4'd7,
        OP_ADDZX  = 4'd8,
        OP_SUBMX  = 4'd9,
        OP_SUBZX  = 4'd10,
        OP_ADDOVX = 4'd11
    } op_e;

    // Source of the second adder operand
    typedef enum logic [1:0] {
        SRC_B    = 2'd0,
        SRC_IMM  = 2'd1,
        SRC_ZERO = 2'd2,
        SRC_ONES = 2'd3
    } bsrc_e;

    // Source of the adder carry-in
    typedef enum logic [1:0] {
        CIN_0  = 2'd0,
        CIN_1  = 2'd1,
        CIN_CA = 2'd2,
        CIN_OV = 2'd3
    } csrc_e;

    typedef struct packed {
        logic ca;
        logic ca32;
        logic ov;
        logic ov32;
        logic so;
    } flags_t;

endpackage

// File: rtl/addcy_opsel.sv
// Operand selector. Decodes the opcode into an A inversion, a second-operand
// source and a carry-in source, then forms the adder inputs.
// Assumes the stored flags are presented as they were before this operation.
module addcy_opsel
    import addcy_pkg::*;
#(
    parameter int WIDTH = 64,
    parameter int IMM_W = 16
) (
    input  logic [3:0]       opcode,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    input  logic [IMM_W-1:0] imm,
    input  logic             ca_in,
    input  logic             ov_in,
    output logic [WIDTH-1:0] opa,
    output logic [WIDTH-1:0] opb,
    output logic             cin,
    output logic             legal,
    output logic             alt_ext
);

    localparam int EXT_W = WIDTH - IMM_W;

    logic          inv_a;
    bsrc_e         bsrc;
    csrc_e         csrc;
    logic [WIDTH-1:0] imm_sx;

    // Sign-extend the immediate to the datapath width
    assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};

    // Decode the opcode into operand and carry controls
    always_comb begin
        inv_a   = 1'b0;
        bsrc    = SRC_B;
        csrc    = CIN_0;
        legal   = 1'b1;
        alt_ext = 1'b0;
        case (opcode)
            OP_ADD:    begin end
            OP_ADDI:   bsrc = SRC_IMM;
            OP_SUB:    begin inv_a = 1'b1; csrc = CIN_1; end
            OP_SUBI:   begin inv_a = 1'b1; bsrc = SRC_IMM; csrc = CIN_1; end
            OP_NEG:    begin inv_a = 1'b1; bsrc = SRC_ZERO; csrc = CIN_1; end
            OP_ADDX:   csrc = CIN_CA;
            OP_SUBX:   begin inv_a = 1'b1; csrc = CIN_CA; end
            OP_ADDMX:  begin bsrc = SRC_ONES; csrc = CIN_CA; end
            OP_ADDZX:  begin bsrc = SRC_ZERO; csrc = CIN_CA; end
            OP_SUBMX:  begin inv_a = 1'b1; bsrc = SRC_ONES; csrc = CIN_CA; end
            OP_SUBZX:  begin inv_a = 1'b1; bsrc = SRC_ZERO; csrc = CIN_CA; end
            OP_ADDOVX: begin csrc = CIN_OV; alt_ext = 1'b1; end
            default:   legal = 1'b0;
        endcase
    end

    // Form the adder operands and carry-in from the decoded controls
    always_comb begin
        opa = inv_a ? ~src_a : src_a;
        case (bsrc)
            SRC_B:    opb = src_b;
            SRC_IMM:  opb = imm_sx;
            SRC_ZERO: opb = '0;
            default:  opb = '1;
        endcase
        case (csrc)
            CIN_0:   cin = 1'b0;
            CIN_1:   cin = 1'b1;
            CIN_CA:  cin = ca_in;
            default: cin = ov_in;
        endcase
    end

endmodule

// File: rtl/addcy_adder.sv
// Single adder with carry taps at full and half width.
// The carry into a bit is recovered as sum XOR a XOR b, so one carry chain
// gives the carries out of bits W-1, W-2, W/2-1 and W/2-2. Assumes WIDTH is even.
module addcy_adder #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             c_full,
    output logic             c_full_m1,
    output logic             c_half,
    output logic             c_half_m1
);

    localparam int HALF = WIDTH / 2;

    logic [WIDTH:0] total;

    // One carry chain over the full width plus the carry out
    assign total = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};
    assign sum   = total[WIDTH-1:0];

    // Recover carries at the tap points
    always_comb begin
        c_full    = total[WIDTH];
        c_full_m1 = total[WIDTH-1] ^ opa[WIDTH-1] ^ opb[WIDTH-1];
        c_half    = total[HALF] ^ opa[HALF] ^ opb[HALF];
        c_half_m1 = total[HALF-1] ^ opa[HALF-1] ^ opb[HALF-1];
    end

endmodule

// File: rtl/addcy_flagreg.sv
// Five-bit flag file with separate carry and overflow write ports and a sticky
// summary overflow. Synchronous active-low reset clears every flag.
module addcy_flagreg
    import addcy_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_ca,
    input  logic   ca_d,
    input  logic   ca32_d,
    input  logic   wr_ov,
    input  logic   ov_d,
    input  logic   ov32_d,
    input  logic   so_set,
    output flags_t flags
);

    // Hold or update each flag group on the clock edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            if (wr_ca) begin
                flags.ca   <= ca_d;
                flags.ca32 <= ca32_d;
            end
            if (wr_ov) begin
                flags.ov   <= ov_d;
                flags.ov32 <= ov32_d;
            end
            if (so_set) begin
                flags.so <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/addcy_unit.sv
// Top of the add-family carry and overflow unit. The operand selector feeds one
// adder, and the result flags are written to the flag file under the two enables.
// Assumes opcode and enables are stable during the cycle that valid is high.
module addcy_unit
    import addcy_pkg::*;
#(
    parameter int WIDTH = 64,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [3:0]       opcode,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    input  logic [IMM_W-1:0] imm,
    input  logic             ca_wen,
    input  logic             ov_wen,
    output logic [WIDTH-1:0] sum,
    output logic             res_ca,
    output logic             res_ca32,
    output logic             res_ov,
    output logic             res_ov32,
    output logic             illegal,
    output logic             flag_ca,
    output logic             flag_ca32,
    output logic             flag_ov,
    output logic             flag_ov32,
    output logic             flag_so
);

    flags_t           flags;
    logic [WIDTH-1:0] opa;
    logic [WIDTH-1:0] opb;
    logic             cin;
    logic             legal;
    logic             alt_ext;
    logic             c_full;
    logic             c_full_m1;
    logic             c_half;
    logic             c_half_m1;
    logic             commit;

    addcy_opsel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_opsel (
        .opcode  (opcode),
        .src_a   (src_a),
        .src_b   (src_b),
        .imm     (imm),
        .ca_in   (flags.ca),
        .ov_in   (flags.ov),
        .opa     (opa),
        .opb     (opb),
        .cin     (cin),
        .legal   (legal),
        .alt_ext (alt_ext)
    );

    addcy_adder #(.WIDTH(WIDTH)) u_adder (
        .opa       (opa),
        .opb       (opb),
        .cin       (cin),
        .sum       (sum),
        .c_full    (c_full),
        .c_full_m1 (c_full_m1),
        .c_half    (c_half),
        .c_half_m1 (c_half_m1)
    );

    // Result flags. The overflow-carry variant reports its carries as overflow
    always_comb begin
        res_ca   = c_full;
        res_ca32 = c_half;
        res_ov   = alt_ext ? c_full : (c_full ^ c_full_m1);
        res_ov32 = alt_ext ? c_half : (c_half ^ c_half_m1);
        commit   = valid & legal;
        illegal  = valid & ~legal;
    end

    addcy_flagreg u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ca  (commit & ca_wen & ~alt_ext),
        .ca_d   (res_ca),
        .ca32_d (res_ca32),
        .wr_ov  (commit & (ov_wen | (ca_wen & alt_ext))),
        .ov_d   (res_ov),
        .ov32_d (res_ov32),
        .so_set (commit & ov_wen & res_ov),
        .flags  (flags)
    );

    // Expose the stored flags
    always_comb begin
        flag_ca   = flags.ca;
        flag_ca32 = flags.ca32;
        flag_ov   = flags.ov;
        flag_ov32 = flags.ov32;
        flag_so   = flags.so;
    end

endmodule

// File: rtl/addcy_unit_chk.sv
// Checker for addcy_unit. Observes the top-level ports only and is attached
// by the bind statement at the end of this file.
module addcy_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       valid,
    input logic [3:0] opcode,
    input logic       ca_wen,
    input logic       ov_wen,
    input logic       res_ov,
    input logic       res_ov32,
    input logic       illegal,
    input logic       flag_ca,
    input logic       flag_ca32,
    input logic       flag_ov,
    input logic       flag_ov32,
    input logic       flag_so
);

    a_r9_illegal_range: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (valid && opcode >= 4'd12));

    a_r9_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && illegal) |=> $stable({flag_ca, flag_ca32, flag_ov, flag_ov32, flag_so}));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable({flag_ca, flag_ca32, flag_ov, flag_ov32, flag_so}));

    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> ({flag_ca, flag_ca32, flag_ov, flag_ov32, flag_so} == 5'b0));

    a_r7_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_so |=> flag_so);

    a_r7_ov_write: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !illegal && ov_wen) |=>
            (flag_ov == $past(res_ov) && flag_ov32 == $past(res_ov32)));

    a_r8_ca_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid || !ca_wen) |=> $stable({flag_ca, flag_ca32}));

    a_r6_ca_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && opcode == 4'd11) |=> $stable({flag_ca, flag_ca32}));

endmodule

bind addcy_unit addcy_unit_chk u_chk (.*);

// File: tb/addcy_unit_tb.sv
// Directed bench for addcy_unit. Each scenario task checks its own results
// against a 65-bit reference model and a bench-held copy of the flags.
module addcy_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [3:0]  opcode = 4'd0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [15:0] imm = '0;
    logic        ca_wen = 1'b0;
    logic        ov_wen = 1'b0;
    logic [63:0] sum;
    logic        res_ca, res_ca32, res_ov, res_ov32, illegal;
    logic        flag_ca, flag_ca32, flag_ov, flag_ov32, flag_so;

    int checks = 0;
    int errors = 0;
    logic e_ca = 0, e_ca32 = 0, e_ov = 0, e_ov32 = 0, e_so = 0;

    localparam logic [64:0] M31 = 65'h0_0000_0000_7FFF_FFFF;
    localparam logic [64:0] M32 = 65'h0_0000_0000_FFFF_FFFF;
    localparam logic [64:0] M63 = 65'h0_7FFF_FFFF_FFFF_FFFF;
    localparam logic [64:0] M64 = 65'h0_FFFF_FFFF_FFFF_FFFF;

    addcy_unit u_dut (
        .clk(clk), .rst_n(rst_n), .valid(valid), .opcode(opcode),
        .src_a(src_a), .src_b(src_b), .imm(imm), .ca_wen(ca_wen), .ov_wen(ov_wen),
        .sum(sum), .res_ca(res_ca), .res_ca32(res_ca32), .res_ov(res_ov),
        .res_ov32(res_ov32), .illegal(illegal), .flag_ca(flag_ca),
        .flag_ca32(flag_ca32), .flag_ov(flag_ov), .flag_ov32(flag_ov32),
        .flag_so(flag_so)
    );

    always #10 clk = ~clk;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // Reference model built from the requirement text with 65-bit sums
    task automatic model(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                         input logic [15:0] im, input logic cai, input logic ovi,
                         output logic [63:0] s, output logic c64, output logic c32,
                         output logic o64, output logic o32, output logic ok);
        logic [64:0] x, y, c, t;
        logic        c63, c31;
        logic [63:0] imx;
        imx = 64'($signed(im));
        ok = 1'b1;
        x = {1'b0, a}; y = {1'b0, b}; c = 65'd0;
        case (op)
            4'd0:  ;
            4'd1:  y = {1'b0, imx};
            4'd2:  begin x = {1'b0, ~a}; c = 65'd1; end
            4'd3:  begin x = {1'b0, ~a}; y = {1'b0, imx}; c = 65'd1; end
            4'd4:  begin x = {1'b0, ~a}; y = 65'd0; c = 65'd1; end
            4'd5:  c = {64'd0, cai};
            4'd6:  begin x = {1'b0, ~a}; c = {64'd0, cai}; end
            4'd7:  begin y = M64; c = {64'd0, cai}; end
            4'd8:  begin y = 65'd0; c = {64'd0, cai}; end
            4'd9:  begin x = {1'b0, ~a}; y = M64; c = {64'd0, cai}; end
            4'd10: begin x = {1'b0, ~a}; y = 65'd0; c = {64'd0, cai}; end
            4'd11: c = {64'd0, ovi};
            default: ok = 1'b0;
        endcase
        t   = x + y + c;
        s   = t[63:0];
        c64 = t[64];
        t   = (x & M32) + (y & M32) + c; c32 = t[32];
        t   = (x & M63) + (y & M63) + c; c63 = t[63];
        t   = (x & M31) + (y & M31) + c; c31 = t[31];
        if (op == 4'd11) begin
            o64 = c64; o32 = c32;
        end else begin
            o64 = c64 ^ c63; o32 = c32 ^ c31;
        end
    endtask

    task automatic check_flags(input string tag);
        chk({tag, " flag_ca"},   64'(flag_ca),   64'(e_ca));
        chk({tag, " flag_ca32"}, 64'(flag_ca32), 64'(e_ca32));
        chk({tag, " flag_ov"},   64'(flag_ov),   64'(e_ov));
        chk({tag, " flag_ov32"}, 64'(flag_ov32), 64'(e_ov32));
        chk({tag, " flag_so"},   64'(flag_so),   64'(e_so));
    endtask

    // Apply one operation, check the combinational results, then the flags
    task automatic do_op(input string tag, input logic [3:0] op, input logic [63:0] a,
                         input logic [63:0] b, input logic [15:0] im,
                         input logic cw, input logic ow);
        logic [63:0] s;
        logic c64, c32, o64, o32, ok;
        @(negedge clk);
        valid = 1'b1; opcode = op; src_a = a; src_b = b; imm = im;
        ca_wen = cw; ov_wen = ow;
        model(op, a, b, im, e_ca, e_ov, s, c64, c32, o64, o32, ok);
        #2;
        chk({tag, " illegal"}, 64'(illegal), 64'(!ok));
        if (ok) begin
            chk({tag, " sum"},      sum,            s);
            chk({tag, " res_ca"},   64'(res_ca),    64'(c64));
            chk({tag, " res_ca32"}, 64'(res_ca32),  64'(c32));
            chk({tag, " res_ov"},   64'(res_ov),    64'(o64));
            chk({tag, " res_ov32"}, 64'(res_ov32),  64'(o32));
            if (cw && op != 4'd11) begin e_ca = c64; e_ca32 = c32; end
            if (cw && op == 4'd11) begin e_ov = c64; e_ov32 = c32; end
            if (ow) begin e_ov = o64; e_ov32 = o32; e_so = e_so | o64; end
        end
        @(posedge clk);
        #2;
        valid = 1'b0; ca_wen = 1'b0; ov_wen = 1'b0;
        check_flags(tag);
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #2; rst_n = 1'b1;
        e_ca = 0; e_ca32 = 0; e_ov = 0; e_ov32 = 0; e_so = 0;
        check_flags("R10 reset");
    endtask

    task automatic t_plain;
        do_op("R5 max+1",  4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 1'b1, 1'b1);
        do_op("R4 low+1",  4'd0, 64'h0000_0000_FFFF_FFFF, 64'd1, 16'd0, 1'b1, 1'b1);
        do_op("R4 wrap",   4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 1'b1, 1'b1);
        do_op("R2 subf",   4'd2, 64'd5, 64'd3, 16'd0, 1'b1, 1'b1);
        do_op("R2 subf eq",4'd2, 64'd9, 64'd9, 16'd0, 1'b1, 1'b1);
        do_op("R2 neg0",   4'd4, 64'd0, 64'd77, 16'd0, 1'b1, 1'b1);
        do_op("R2 negmin", 4'd4, 64'h8000_0000_0000_0000, 64'd0, 16'd0, 1'b1, 1'b1);
    endtask

    task automatic t_imm;
        do_op("R1 addi neg", 4'd1, 64'h8000, 64'd0, 16'h8000, 1'b1, 1'b1);
        do_op("R1 addi pos", 4'd1, 64'd1, 64'd0, 16'h7FFF, 1'b1, 1'b1);
        do_op("R1 subi neg", 4'd3, 64'd2, 64'd0, 16'hFFFF, 1'b1, 1'b1);
        do_op("R2 subi pos", 4'd3, 64'd100, 64'd0, 16'd40, 1'b1, 1'b1);
    endtask

    task automatic t_extended;
        for (int k = 0; k < 2; k++) begin
            // Set the stored carry to k: 0+0 gives no carry, ones+1 gives carry
            do_op("R3 prep", 4'd0, k ? 64'hFFFF_FFFF_FFFF_FFFF : 64'd0, 64'(k), 16'd0, 1'b1, 1'b0);
            for (int op = 5; op <= 10; op++) begin
                do_op("R3 ext", 4'(op), 64'h0000_0001_FFFF_FFFF, 64'h7FFF_FFFF_0000_0001, 16'd0, 1'b0, 1'b0);
                do_op("R3 ext0", 4'(op), 64'd0, 64'd0, 16'd0, 1'b0, 1'b0);
            end
        end
    endtask

    task automatic t_ovcarry;
        do_op("R6 set ov", 4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 1'b1, 1'b1);
        do_op("R6 ovx",    4'd11, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'd0, 1'b1, 1'b0);
        do_op("R6 ovx2",   4'd11, 64'h0000_0000_FFFF_FFFF, 64'd0, 16'd0, 1'b1, 1'b0);
        do_op("R6 ovx3",   4'd11, 64'd3, 64'd4, 16'd0, 1'b1, 1'b0);
    endtask

    task automatic t_sticky;
        do_op("R7 ovf",   4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 1'b0, 1'b1);
        do_op("R7 clear", 4'd0, 64'd1, 64'd2, 16'd0, 1'b0, 1'b1);
    endtask

    task automatic t_ca_gate;
        do_op("R8 gated", 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'd0, 1'b0, 1'b0);
        do_op("R8 write", 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'd0, 1'b1, 1'b0);
        do_op("R8 gated0", 4'd0, 64'd1, 64'd1, 16'd0, 1'b0, 1'b1);
    endtask

    task automatic t_illegal;
        do_op("R9 op12", 4'd12, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 1'b1, 1'b1);
        do_op("R9 op15", 4'd15, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 1'b1, 1'b1);
        // Idle cycle with a bad opcode and enables: nothing reported, nothing written
        @(negedge clk);
        valid = 1'b0; opcode = 4'd13; ca_wen = 1'b1; ov_wen = 1'b1;
        src_a = 64'hFFFF_FFFF_FFFF_FFFF; src_b = 64'd1;
        #2;
        chk("R9 idle illegal", 64'(illegal), 64'd0);
        @(posedge clk); #2;
        ca_wen = 1'b0; ov_wen = 1'b0;
        check_flags("R10 idle");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_plain();
        t_imm();
        t_extended();
        t_ovcarry();
        t_sticky();
        t_ca_gate();
        t_illegal();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule